// File: doc/BRIEF.md
# I2C Slave Receiver with Two-Byte (10-bit) Address Recognition

This block is an I2C slave that only receives. It matches a 10-bit address that arrives as two bytes, using one compare register. Software loads the compare register with the high address byte (`11110`, address bits 9:8, and a zero write bit) before a transfer. When that byte matches, the block acknowledges it, raises an update-address flag and holds SCL low. Software then writes the low address byte into the same register, and that write releases the clock. After the low byte matches, the block raises the flag again so that software can put the high byte back. Data bytes follow.

SCL and SDA are sampled on the system clock through a short synchronizer. Start and Stop are found from SDA edges while SCL is high. Bytes are shifted in on SCL rising edges. The acknowledge is driven on the ninth clock pulse through an open-drain enable. An optional stretch mode makes software release SCL after each data byte. A small four-word register port gives access to the compare register, the receive buffer, control and status. One interrupt flag collects all events.

Top module: `i2c10_slave_rx`

## Requirements
- R1: A Start condition (SDA falling while SCL is high) sets the start-seen status bit (status bit 2). It sets the interrupt flag (status bit 3 and port `irq`) only when start-interrupt-enable (control bit 2) is 1. A Stop clears start-seen.
- R2: After a Start, the first byte is accepted only when its upper seven bits equal the compare register's upper seven bits and its bit 0 (read/write) is 0. An accepted byte is acknowledged and sets update-address, buffer-full and interrupt. Any other first byte gets no ACK, sets no flag, and makes the block ignore the bus until the next Start.
- R3: After an accepted address byte, SCL is held low until a write to the compare register is accepted. That write releases SCL and clears update-address.
- R4: A read of the receive buffer (offset 1) returns the last captured byte and clears buffer-full.
- R5: A second byte equal to the whole compare register is acknowledged and sets update-address, buffer-full and interrupt, with SCL held as in R3.
- R6: A second byte that does not equal the compare register still sets interrupt and update-address. It is not acknowledged, does not set buffer-full, leaves the clock-release bit unchanged and does not hold SCL.
- R7: Every byte after a matched address pair is acknowledged on the ninth SCL pulse, captured into the receive buffer, and sets buffer-full and interrupt. The slave changes SDA only while SCL is low.
- R8: With stretch-enable (control bit 1) set, the clock-release bit (control bit 0) is cleared by hardware after each data byte and SCL stays low until software writes it back to 1. With stretch-enable clear, data bytes do not hold SCL.
- R9: A write to the compare register is ignored while an acknowledge slot is in progress, from the falling edge after the eighth data bit to the falling edge ending the ninth pulse.
- R10: A Stop returns the block to idle. Bytes clocked after it without a new Start are not acknowledged and set no flag.
- R11: Register offsets are: 0 compare, 1 receive buffer, 2 control, 3 status (bit 0 buffer-full, bit 1 update-address). Writing 1 to status bit 2 or bit 3 clears that bit. After reset, SCL and SDA are released, status reads 0 and control reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| irq | output | 1 | Interrupt flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on receive buffer) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | BYTE_W | Register write data |
| reg_rdata | output | BYTE_W | Register read data (combinational) |

## Verification
The bench builds the block with its defaults: 8-bit bytes and a two-stage synchronizer. With these values the real header pattern (`11110xx0`) is compared against the register, and the three-to-four-cycle path from a pin to a flag fits inside a ten-clock bus half-period. The bench can therefore write the compare register in the middle of the ninth pulse, which is inside the acknowledge lock window. It also checks every flag at the end of each byte without racing the synchronizer.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_AHI  = 3'd1,
    ST_ALO  = 3'd2,
    ST_DATA = 3'd3,
    ST_SKIP = 3'd4
  } rx_state_e;

  localparam logic [1:0] RA_CMP = 2'd0;
  localparam logic [1:0] RA_RXB = 2'd1;
  localparam logic [1:0] RA_CTL = 2'd2;
  localparam logic [1:0] RA_STA = 2'd3;

  localparam int CB_REL   = 0;
  localparam int CB_STR   = 1;
  localparam int CB_SIE   = 2;

  localparam int SB_BF    = 0;
  localparam int SB_UA    = 1;
  localparam int SB_START = 2;
  localparam int SB_IRQ   = 3;

endpackage

// File: rtl/i2c10_pin_sync.sv
module i2c10_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_ff, scl_ff_n;
  logic [SYNC_STAGES-1:0] sda_ff, sda_ff_n;
  logic scl_d, sda_d;
  logic scl_s;

  always_comb begin
    scl_ff_n = {scl_ff[SYNC_STAGES-2:0], scl_i};
    sda_ff_n = {sda_ff[SYNC_STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= scl_ff_n;
      sda_ff <= sda_ff_n;
      scl_d  <= scl_ff[LAST];
      sda_d  <= sda_ff[LAST];
    end
  end

  assign scl_s     = scl_ff[LAST];
  assign sda_s     = sda_ff[LAST];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c10_rx_shift.sv
module i2c10_rx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ack_begin,
  output logic              byte_end
);

  localparam int CW = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [CW-1:0] CNT_ACK = CW'(BYTE_W);
  localparam logic [CW-1:0] CNT_END = CW'(BYTE_W + 1);

  logic [CW-1:0]     cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              ab_n, be_n;

  always_comb begin
    cnt_n = cnt;
    sh_n  = sh;
    ab_n  = 1'b0;
    be_n  = 1'b0;
    if (bus_reset) begin
      cnt_n = '0;
    end else if (scl_rise) begin
      if (cnt < CNT_ACK) begin
        sh_n  = {sh[BYTE_W-2:0], sda_s};
        cnt_n = cnt + CNT_ONE;
      end else if (cnt == CNT_ACK) begin
        cnt_n = CNT_END;
      end
    end else if (scl_fall) begin
      if (cnt == CNT_ACK) begin
        ab_n = 1'b1;
      end else if (cnt == CNT_END) begin
        be_n  = 1'b1;
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sh        <= '0;
      ack_begin <= 1'b0;
      byte_end  <= 1'b0;
    end else begin
      cnt       <= cnt_n;
      sh        <= sh_n;
      ack_begin <= ab_n;
      byte_end  <= be_n;
    end
  end

  assign rx_byte = sh;

  // R7: the acknowledge slot opens and closes on distinct falling edges
  a_r7_slot_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    ack_begin |=> !byte_end);

endmodule

// File: rtl/i2c10_rx_ctrl.sv
module i2c10_rx_ctrl
  import i2c10_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              ack_begin,
  input  logic              byte_end,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              scl_hold,
  output logic              sda_drive,
  output logic              irq
);

  rx_state_e         state, state_n;
  logic [BYTE_W-1:0] cmp, cmp_n;
  logic [BYTE_W-1:0] rxbuf, rxbuf_n;
  logic rel, rel_n, str_en, str_en_n, sie, sie_n;
  logic bfull, bfull_n, ua, ua_n, start_seen, start_seen_n, irq_q, irq_n;
  logic hold_ua, hold_ua_n, sda_drv, sda_drv_n, ack_win, ack_win_n, ack_q, ack_q_n;
  logic match_hi, match_lo, ack_want;
  logic wr_cmp, wr_ctl, wr_sta, rd_rxb;

  assign match_hi = (rx_byte[BYTE_W-1:1] == cmp[BYTE_W-1:1]) && !rx_byte[0];
  assign match_lo = (rx_byte == cmp);

  assign wr_cmp = reg_wr && (reg_addr == RA_CMP) && !ack_win;
  assign wr_ctl = reg_wr && (reg_addr == RA_CTL);
  assign wr_sta = reg_wr && (reg_addr == RA_STA);
  assign rd_rxb = reg_rd && (reg_addr == RA_RXB);

  always_comb begin
    unique case (state)
      ST_AHI:  ack_want = match_hi;
      ST_ALO:  ack_want = match_lo;
      ST_DATA: ack_want = 1'b1;
      default: ack_want = 1'b0;
    endcase
  end

  always_comb begin
    state_n      = state;
    cmp_n        = cmp;
    rxbuf_n      = rxbuf;
    rel_n        = rel;
    str_en_n     = str_en;
    sie_n        = sie;
    bfull_n      = bfull;
    ua_n         = ua;
    start_seen_n = start_seen;
    irq_n        = irq_q;
    hold_ua_n    = hold_ua;
    sda_drv_n    = sda_drv;
    ack_win_n    = ack_win;
    ack_q_n      = ack_q;

    // software side
    if (wr_cmp) begin
      cmp_n     = reg_wdata;
      ua_n      = 1'b0;
      hold_ua_n = 1'b0;
    end
    if (wr_ctl) begin
      rel_n    = reg_wdata[CB_REL];
      str_en_n = reg_wdata[CB_STR];
      sie_n    = reg_wdata[CB_SIE];
    end
    if (wr_sta) begin
      if (reg_wdata[SB_IRQ])   irq_n        = 1'b0;
      if (reg_wdata[SB_START]) start_seen_n = 1'b0;
    end
    if (rd_rxb) bfull_n = 1'b0;

    // bus side, takes priority over software
    if (start_det) begin
      state_n      = ST_AHI;
      start_seen_n = 1'b1;
      if (sie) irq_n = 1'b1;
      sda_drv_n    = 1'b0;
      ack_win_n    = 1'b0;
    end else if (stop_det) begin
      state_n      = ST_IDLE;
      start_seen_n = 1'b0;
      sda_drv_n    = 1'b0;
      ack_win_n    = 1'b0;
    end else if (ack_begin) begin
      ack_win_n = 1'b1;
      ack_q_n   = ack_want;
      sda_drv_n = ack_want;
    end else if (byte_end) begin
      ack_win_n = 1'b0;
      sda_drv_n = 1'b0;
      unique case (state)
        ST_AHI: begin
          if (ack_q) begin
            rxbuf_n   = rx_byte;
            bfull_n   = 1'b1;
            ua_n      = 1'b1;
            irq_n     = 1'b1;
            hold_ua_n = 1'b1;
            state_n   = ST_ALO;
          end else begin
            state_n = ST_SKIP;
          end
        end
        ST_ALO: begin
          ua_n  = 1'b1;
          irq_n = 1'b1;
          if (ack_q) begin
            rxbuf_n   = rx_byte;
            bfull_n   = 1'b1;
            hold_ua_n = 1'b1;
            state_n   = ST_DATA;
          end else begin
            state_n = ST_SKIP;
          end
        end
        ST_DATA: begin
          rxbuf_n = rx_byte;
          bfull_n = 1'b1;
          irq_n   = 1'b1;
          if (str_en) rel_n = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cmp        <= '0;
      rxbuf      <= '0;
      rel        <= 1'b1;
      str_en     <= 1'b0;
      sie        <= 1'b0;
      bfull      <= 1'b0;
      ua         <= 1'b0;
      start_seen <= 1'b0;
      irq_q      <= 1'b0;
      hold_ua    <= 1'b0;
      sda_drv    <= 1'b0;
      ack_win    <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      state      <= state_n;
      cmp        <= cmp_n;
      rxbuf      <= rxbuf_n;
      rel        <= rel_n;
      str_en     <= str_en_n;
      sie        <= sie_n;
      bfull      <= bfull_n;
      ua         <= ua_n;
      start_seen <= start_seen_n;
      irq_q      <= irq_n;
      hold_ua    <= hold_ua_n;
      sda_drv    <= sda_drv_n;
      ack_win    <= ack_win_n;
      ack_q      <= ack_q_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CMP: reg_rdata = cmp;
      RA_RXB: reg_rdata = rxbuf;
      RA_CTL: begin
        reg_rdata[CB_REL] = rel;
        reg_rdata[CB_STR] = str_en;
        reg_rdata[CB_SIE] = sie;
      end
      default: begin
        reg_rdata[SB_BF]    = bfull;
        reg_rdata[SB_UA]    = ua;
        reg_rdata[SB_START] = start_seen;
        reg_rdata[SB_IRQ]   = irq_q;
      end
    endcase
  end

  assign scl_hold  = hold_ua | ~rel;
  assign sda_drive = sda_drv;
  assign irq       = irq_q;

  a_r1_start_flag: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> start_seen);

  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE));

  a_r9_cmp_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_CMP) && ack_win) |=> (cmp == $past(cmp)));

  a_r4_bf_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bfull) |-> $past(byte_end));

  a_r7_drive_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drv |-> ack_win);

  a_r3_release_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ua) |-> $past(reg_wr && (reg_addr == RA_CMP)));

  a_r6_miss_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && (state == ST_ALO) && !ack_q) |=> (ua && irq_q && !hold_ua));

endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata
);

  logic [1:0] rst_ff;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ack_begin, byte_end;
  logic [BYTE_W-1:0] rx_byte;

  i2c10_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c10_rx_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_reset (start_det | stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .rx_byte   (rx_byte),
    .ack_begin (ack_begin),
    .byte_end  (byte_end)
  );

  i2c10_rx_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .ack_begin (ack_begin),
    .byte_end  (byte_end),
    .rx_byte   (rx_byte),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .scl_hold  (scl_oe),
    .sda_drive (sda_oe),
    .irq       (irq)
  );

endmodule

// File: tb/i2c10_slave_rx_tb.sv
module i2c10_slave_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  wire scl_line = m_scl & ~scl_oe;
  wire sda_line = m_sda & ~sda_oe;

  i2c10_slave_rx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference model
  int m_st = 0; // 0 idle, 1 high addr, 2 low addr, 3 data, 4 ignore
  logic [7:0] m_cmp = 8'h00, m_buf = 8'h00;
  bit m_rel = 1, m_str = 0, m_sie = 0, m_bf = 0, m_ua = 0, m_start = 0, m_irq = 0, m_hold = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_wr(logic [1:0] a, logic [7:0] d, bit in_slot);
    case (a)
      2'd0: if (!in_slot) begin m_cmp = d; m_ua = 0; m_hold = 0; end
      2'd2: begin m_rel = d[0]; m_str = d[1]; m_sie = d[2]; end
      2'd3: begin if (d[3]) m_irq = 0; if (d[2]) m_start = 0; end
      default: ;
    endcase
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr(a, d);
    model_wr(a, d, 1'b0);
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    if (a == 2'd1) m_bf = 0;
  endtask

  task automatic check_state(string tag);
    logic [7:0] d;
    rd(2'd3, d);
    chk({tag, " status"}, d, {4'b0, m_irq, m_start, m_ua, m_bf});
    rd(2'd2, d);
    chk({tag, " control"}, d, {5'b0, m_sie, m_str, m_rel});
    chk({tag, " scl_oe"}, scl_oe, m_hold | !m_rel);
    chk({tag, " irq port"}, irq, m_irq);
  endtask

  task automatic wait_scl;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic do_start;
    m_sda = 1'b1; hw(H);
    m_scl = 1'b1; wait_scl; hw(H);
    m_sda = 1'b0; hw(H);
    m_scl = 1'b0; hw(H);
    m_st = 1; m_start = 1; if (m_sie) m_irq = 1;
  endtask

  task automatic do_stop;
    m_sda = 1'b0; hw(H);
    m_scl = 1'b1; wait_scl; hw(H);
    m_sda = 1'b1; hw(H);
    m_st = 0; m_start = 0;
  endtask

  task automatic model_byte(logic [7:0] b, output bit ack);
    ack = 0;
    case (m_st)
      1: if (b[7:1] == m_cmp[7:1] && !b[0]) begin
           ack = 1; m_bf = 1; m_ua = 1; m_irq = 1; m_buf = b; m_hold = 1; m_st = 2;
         end else m_st = 4;
      2: begin
           m_ua = 1; m_irq = 1;
           if (b == m_cmp) begin ack = 1; m_bf = 1; m_buf = b; m_hold = 1; m_st = 3; end
           else m_st = 4;
         end
      3: begin ack = 1; m_bf = 1; m_irq = 1; m_buf = b; if (m_str) m_rel = 0; end
      default: ;
    endcase
  endtask

  task automatic send_byte(string tag, logic [7:0] b, bit mid, logic [7:0] wv);
    bit got, exp;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(H);
      m_scl = 1'b1; wait_scl; hw(H);
      m_scl = 1'b0; hw(2);
    end
    m_sda = 1'b1; hw(H);
    m_scl = 1'b1; wait_scl; hw(H/2);
    got = !sda_line;
    if (mid) begin bus_wr(2'd0, wv); model_wr(2'd0, wv, 1'b1); end
    hw(H/2);
    m_scl = 1'b0; hw(H);
    model_byte(b, exp);
    chk({tag, " ack"}, got, exp);
  endtask

  // R7: the slave never moves SDA while the clock line stays high
  logic prev_sda_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_scl && scl_line) chk("R7 sda steady while SCL high", sda_oe, prev_sda_oe);
      prev_sda_oe <= sda_oe;
      prev_scl    <= scl_line;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual run still busy expected finished");
      finish_run;
    end
  end

  initial begin
    logic [7:0] d;
    hw(5); rst_n = 1'b1; hw(5);

    // R11 reset state and map
    chk("R11 scl_oe", scl_oe, 0);
    chk("R11 sda_oe", sda_oe, 0);
    check_state("R11");

    wr(2'd0, 8'hF2);
    wr(2'd2, 8'h07);

    // R1 start with interrupt enabled
    do_start();
    check_state("R1");
    wr(2'd3, 8'h0C);

    // R2 high byte match, R3 hold
    send_byte("R2", 8'hF2, 0, 8'h00);
    check_state("R2");
    hw(40);
    chk("R3 still held", scl_oe, 1);
    rd(2'd1, d);
    chk("R4 rx buffer", d, 8'hF2);
    check_state("R4");
    wr(2'd3, 8'h08);
    wr(2'd0, 8'hA5);
    hw(2);
    check_state("R3 released");

    // R5 low byte match
    send_byte("R5", 8'hA5, 0, 8'h00);
    check_state("R5");
    rd(2'd1, d);
    chk("R5 rx buffer", d, 8'hA5);
    wr(2'd0, 8'hF2);
    wr(2'd3, 8'h08);
    check_state("R5 restored");

    // R7 and R8 data byte with stretch
    send_byte("R7", 8'h3C, 0, 8'h00);
    check_state("R8 stretched");
    rd(2'd1, d);
    chk("R7 rx buffer", d, 8'h3C);
    wr(2'd2, 8'h07);
    hw(2);
    check_state("R8 released");
    wr(2'd3, 8'h08);

    // R9 write during ack slot, stretch disabled
    wr(2'd2, 8'h05);
    send_byte("R9", 8'h81, 1, 8'h00);
    rd(2'd0, d);
    chk("R9 compare kept", d, 8'hF2);
    check_state("R8 no stretch");
    rd(2'd1, d);
    chk("R7 second byte", d, 8'h81);
    wr(2'd3, 8'h08);

    // R10 stop then bytes without start
    do_stop();
    check_state("R10 after stop");
    send_byte("R10", 8'hF2, 0, 8'h00);
    check_state("R10 ignored");

    // R1 start without interrupt, R6 low miss
    wr(2'd2, 8'h03);
    do_start();
    check_state("R1 no irq");
    send_byte("R2 second", 8'hF2, 0, 8'h00);
    rd(2'd1, d);
    wr(2'd0, 8'hA5);
    wr(2'd3, 8'h08);
    send_byte("R6", 8'h77, 0, 8'h00);
    check_state("R6");
    wr(2'd0, 8'hF2);
    check_state("R6 restored");
    wr(2'd3, 8'h0C);
    do_stop();

    // R2 wrong header and read direction
    do_start();
    send_byte("R2 wrong", 8'hF4, 0, 8'h00);
    send_byte("R2 skipped", 8'hF2, 0, 8'h00);
    check_state("R2 wrong");
    do_stop();
    do_start();
    send_byte("R2 read bit", 8'hF3, 0, 8'h00);
    check_state("R2 read bit");
    do_stop();

    hw(5);
    finish_run;
  end

endmodule